// File: doc/BRIEF.md
# Mixed-Sign Fractional Multiplier with Unsigned Sequencer

The block multiplies two 16-bit operands and leaves the product in a 36-bit accumulator. The core always reads the first operand as a signed two's complement number and the second as an unsigned number. The 32-bit raw product is doubled to fractional alignment and sign-extended through the 4 guard bits. The caller picks one of two operations with `uns_mode`. A mixed multiply runs the core once. A full unsigned multiply clears the top bit of the first operand, multiplies, and then adds the second operand into the accumulator's middle word when the cleared bit was set. With `int_mode` set, a final arithmetic shift right by one turns the fractional result into an integer product.

A one-cycle `start` strobe captures the operands and both mode bits. The sequencer then steps through one state per cycle: multiply, an optional correction and an optional shift. It then raises `done` for exactly one cycle. The result holds its value until a later accepted start overwrites it.

Top module: `frac_su_mult`

## Requirements
- R1: After reset `result` is 0 and `done` is 0.
- R2: With `uns_mode`=0 and `int_mode`=0, `result` equals 2·A·B as a 36-bit two's complement value. Here A is `op_a` read as signed and B is `op_b` read as unsigned. Bit 0 of any fractional result is 0.
- R3: With `uns_mode`=1 and `int_mode`=0, `result` equals 2·A·B with both operands unsigned. Such a result is never negative, so bit 35 is 0.
- R4: With `int_mode`=1, `result` equals A·B, read with the signedness of the selected mode and without the doubling. The shift state is entered only in this mode.
- R5: `done` is high in the cycle that follows the start edge by 1+c+s clock edges. c is 1 only when `uns_mode`=1 and bit 15 of `op_a` is 1. s is 1 only when `int_mode`=1. The correction state runs only when c is 1.
- R6: `done` lasts exactly one cycle. `result` does not change while the block is idle or in its done cycle.
- R7: A `start` raised while a multiply is in progress is ignored. The operands and modes presented with it have no effect on the running result or its latency.
- R8: A `start` raised in the done cycle is accepted as a back-to-back operation. The previous result stays visible for one further cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted when idle or in the done cycle) |
| uns_mode | input | 1 | 1: both operands unsigned; 0: first signed, second unsigned |
| int_mode | input | 1 | 1: integer result (shift right by one); 0: fractional result |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| result | output | 36 | Accumulator: product, 4 guard bits on top |
| done | output | 1 | One-cycle completion pulse |

## Verification
The completion pulse of one operation and the acceptance of the next start can land in the same cycle. The bench provokes this by raising `start` with new operands at the sample where `done` is seen high. It then judges that the old product is still on `result` one cycle later and that the new product arrives with its own computed latency. A start raised during the multiply state is treated the same way. In that case the first operation's product and latency must come out untouched.

// File: rtl/frac_su_mult.sv
module frac_su_mult #(
  parameter int W     = 16,
  parameter int GUARD = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   uns_mode,
  input  logic                   int_mode,
  input  logic [W-1:0]           op_a,
  input  logic [W-1:0]           op_b,
  output logic [2*W+GUARD-1:0]   result,
  output logic                   done
);

  localparam int PW    = 2 * W;
  localparam int ACC_W = PW + GUARD;

  typedef enum logic [2:0] {S_IDLE, S_MULT, S_CORR, S_SHIFT, S_DONE} st_t;

  st_t              st_q, st_d;
  logic [W-1:0]     a_q, b_q;
  logic             uns_q, int_q;
  logic [ACC_W-1:0] acc_q;

  wire accept    = start && (st_q == S_IDLE || st_q == S_DONE);
  wire need_corr = uns_q && a_q[W-1];

  wire [W-1:0] a_eff = uns_q ? {1'b0, a_q[W-2:0]} : a_q;

  wire signed [PW-1:0] a_ext = {{W{a_eff[W-1]}}, a_eff};
  wire signed [PW-1:0] b_ext = {{W{1'b0}}, b_q};
  wire signed [PW-1:0] prod  = a_ext * b_ext;

  wire [ACC_W-1:0] frac_prod = {{(GUARD-1){prod[PW-1]}}, prod, 1'b0};
  wire [ACC_W-1:0] corr_term = {{GUARD{1'b0}}, b_q, {W{1'b0}}};

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:  if (accept) st_d = S_MULT;
      S_MULT:  st_d = need_corr ? S_CORR : (int_q ? S_SHIFT : S_DONE);
      S_CORR:  st_d = int_q ? S_SHIFT : S_DONE;
      S_SHIFT: st_d = S_DONE;
      S_DONE:  st_d = accept ? S_MULT : S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      a_q   <= '0;
      b_q   <= '0;
      uns_q <= 1'b0;
      int_q <= 1'b0;
      acc_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        a_q   <= op_a;
        b_q   <= op_b;
        uns_q <= uns_mode;
        int_q <= int_mode;
      end
      case (st_q)
        S_MULT:  acc_q <= frac_prod;
        S_CORR:  acc_q <= acc_q + corr_term;
        S_SHIFT: acc_q <= {acc_q[ACC_W-1], acc_q[ACC_W-1:1]};
        default: ;
      endcase
    end
  end

  assign result = acc_q;
  assign done   = (st_q == S_DONE);

  assert_frac_lsb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !int_q) |-> !result[0]);

  assert_uns_nonneg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && uns_q) |-> !result[ACC_W-1]);

  assert_shift_int_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SHIFT) |-> int_q);

  assert_corr_when_needed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_CORR) |-> (uns_q && a_q[W-1]));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE || st_q == S_DONE) |=> $stable(acc_q));

  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_MULT || st_q == S_CORR || st_q == S_SHIFT) |=> $stable(a_q) && $stable(b_q));

endmodule

// File: tb/tb_frac_su_mult.sv
module tb_frac_su_mult;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, uns_mode = 1'b0, int_mode = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [35:0] result;
  logic        done;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  frac_su_mult dut (.clk(clk), .rst_n(rst_n), .start(start), .uns_mode(uns_mode),
                    .int_mode(int_mode), .op_a(op_a), .op_b(op_b),
                    .result(result), .done(done));

  localparam int NV = 16;
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'h4000, 16'h8000}, {1'b0, 1'b0, 16'h8000, 16'hFFFF},
    {1'b0, 1'b0, 16'hFFFF, 16'h0001}, {1'b0, 1'b1, 16'h8000, 16'hFFFF},
    {1'b0, 1'b1, 16'h1234, 16'h5678}, {1'b0, 1'b1, 16'hFFFF, 16'hFFFF},
    {1'b1, 1'b0, 16'hFFFF, 16'hFFFF}, {1'b1, 1'b0, 16'h8000, 16'h8000},
    {1'b1, 1'b0, 16'h7FFF, 16'hFFFF}, {1'b1, 1'b1, 16'hFFFF, 16'hFFFF},
    {1'b1, 1'b1, 16'h8001, 16'h0003}, {1'b1, 1'b1, 16'h0000, 16'hFFFF},
    {1'b1, 1'b0, 16'hC350, 16'h0000}, {1'b0, 1'b0, 16'h0000, 16'h0000},
    {1'b1, 1'b1, 16'hABCD, 16'h1357}, {1'b0, 1'b0, 16'h7FFF, 16'h7FFF}
  };

  function automatic logic [35:0] ref_prod(input logic u, input logic im,
                                           input logic [15:0] a, input logic [15:0] b);
    longint p, sa;
    sa = longint'($signed(a));
    if (u) p = longint'(a) * longint'(b);
    else   p = sa * longint'(b);
    if (!im) p = p * 2;
    return p[35:0];
  endfunction

  function automatic int ref_lat(input logic u, input logic im, input logic [15:0] a);
    return 1 + ((u && a[15]) ? 1 : 0) + (im ? 1 : 0);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic u, input logic im, input logic [15:0] a, input logic [15:0] b);
    start = 1'b1; uns_mode = u; int_mode = im; op_a = a; op_b = b;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 20) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_op(input logic u, input logic im, input logic [15:0] a, input logic [15:0] b,
                        input string req);
    int n;
    logic [35:0] e;
    e = ref_prod(u, im, a, b);
    @(negedge clk);
    drive(u, im, a, b);
    @(negedge clk);
    start = 1'b0; op_a = ~a; op_b = ~b; uns_mode = ~u; int_mode = ~im;
    wait_done(n);
    chk(result == e, req, result, e);
    chk(n == ref_lat(u, im, a), "R5 latency", n, ref_lat(u, im, a));
    @(negedge clk);
    chk(!done, "R6 done width", done, 0);
    chk(result == e, "R6 hold", result, e);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    logic [35:0] e1, e2;
    logic [15:0] cv [3];
    cv[0] = 16'h0000; cv[1] = 16'h8000; cv[2] = 16'hFFFF;

    #1;
    chk(result == 36'h0, "R1 result", result, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(result == 36'h0 && !done, "R1 after release", result, 0);

    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      v = VEC[i];
      run_op(v[33], v[32], v[31:16], v[15:0],
             v[32] ? "R4 integer" : (v[33] ? "R3 unsigned frac" : "R2 mixed frac"));
    end

    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < 3; j++)
          run_op(m[1], m[0], cv[i], cv[j], "R2 R3 R4 corner operand");

    // R7: start during the multiply state is ignored
    e1 = ref_prod(1'b1, 1'b1, 16'h9ABC, 16'hDEF0);
    @(negedge clk);
    drive(1'b1, 1'b1, 16'h9ABC, 16'hDEF0);
    @(negedge clk);
    drive(1'b0, 1'b0, 16'h1111, 16'h2222);
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(result == e1, "R7 busy start ignored", result, e1);
    chk(n == 3, "R7 latency unchanged", n, 3);
    @(negedge clk);
    chk(!done && result == e1, "R7 no extra operation", result, e1);

    // R8: start in the done cycle is accepted back to back
    e1 = ref_prod(1'b0, 1'b0, 16'h8001, 16'hF00F);
    e2 = ref_prod(1'b1, 1'b0, 16'hF234, 16'h00FF);
    @(negedge clk);
    drive(1'b0, 1'b0, 16'h8001, 16'hF00F);
    @(negedge clk);
    start = 1'b0;
    wait_done(n);
    chk(result == e1, "R8 first result", result, e1);
    drive(1'b1, 1'b0, 16'hF234, 16'h00FF);
    @(negedge clk);
    start = 1'b0; op_a = 16'h0; op_b = 16'h0;
    chk(result == e1 && !done, "R8 old result held one cycle", result, e1);
    wait_done(n);
    chk(result == e2, "R8 second result", result, e2);
    chk(n == 2, "R8 second latency", n, 2);

    // R6: result held across idle cycles
    repeat (5) @(negedge clk);
    chk(result == e2 && !done, "R6 idle hold", result, e2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule